// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block connects a CPU register bus to a byte-wide nonvolatile data array, modelled here as a synchronous memory. Software reaches it through four 8-bit registers: the low part of the address, the high part of the address, a data byte and a control byte. A read strobe copies the addressed byte into the data register. Before a write can begin, software must arm the block. It first sets a self-clearing enable bit, then sets the write strobe within a short window. The write strobe stays high for the whole timed erase or program operation.

Register select `reg_sel`: 0 = address bits 7:0, 1 = address bits 11:8, 2 = data, 3 = control. Control bits: bit 0 read strobe, bit 1 write strobe (reads back as busy), bit 2 arm enable, bit 3 ready-interrupt enable, bits 5:4 operation mode. Bits 7:6 read as zero and bit 0 reads as zero. Each write to the control register updates the interrupt enable. It also updates the mode, except while an operation is running. Writing 0 to the arm bit has no effect.

Top module: `nvm_access_ctrl`

## Requirements
- R1: The high address register reads back with its upper four bits at zero and the lower four bits holding address bits 11:8. The low address register and the data register read back what was written.
- R2: A write strobe starts an operation only if the arm bit is set at that edge. The arm bit clears by itself four clock edges after the write that set it. A strobe on the fourth following edge is accepted, and a strobe on the fifth is ignored with the array left unchanged. A strobe without arming does nothing.
- R3: The mode field decodes as follows: 00 = erase then program in one operation, 01 = erase only, 10 = program only. A write strobe with mode 11 is refused.
- R4: The busy bit (control bit 1) stays high for exactly T_ATOMIC cycles for mode 00, and for exactly T_SPLIT cycles for modes 01 and 10. Hardware then clears it.
- R5: A write strobe is refused while `flash_busy` is high.
- R6: When the operation ends, mode 00 stores the data byte, mode 01 leaves 0xFF, and mode 10 stores the old byte AND the data byte.
- R7: Control writes during an operation leave the mode field unchanged.
- R8: During an operation, writes to the address and data registers are ignored, and a read strobe neither changes the data register nor stalls the CPU.
- R9: A read strobe returns the addressed byte in the data register and holds `cpu_stall` high for 4 cycles. Starting a write holds it high for 2 cycles.
- R10: `ready_irq` is high whenever the interrupt enable is set and no operation is running. Otherwise it is low.
- R11: After reset, all registers read zero and `cpu_stall` and `ready_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| flash_busy | input | 1 | High while program memory self-programming runs; blocks writes |
| cpu_stall | output | 1 | Holds the CPU after an access |
| ready_irq | output | 1 | Ready interrupt request |

## Verification
The bench places the write strobe exactly at the last edge of the arm window and one edge past it. A design with an off-by-one window would start the late write and corrupt the byte, or refuse the timely one. It measures busy length in cycles for the combined and split modes, so a design that swaps the two durations or is one cycle short fails there. It attempts mode, address, data and read-strobe changes while an operation is running, and it tries refused writes with mode 11 and with the external busy input high. A leaky design would then commit to the wrong cell or start an operation it should have blocked. Random mode, data and window-gap sequences are checked against a byte model that treats program-only as a bitwise AND.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_ATOMIC  = 2'b00,
    OP_ERASE   = 2'b01,
    OP_PROGRAM = 2'b10,
    OP_RSVD    = 2'b11
  } nvm_op_e;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_DATA    = 2'd2;
  localparam logic [1:0] SEL_CTRL    = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IEN  = 3;
  localparam int CB_MODE = 4;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (consume_i)        cnt_d = '0;
    else if (set_i)       cnt_d = CW'(WINDOW);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed_o = (cnt_q != '0);

  // R2: the window never exceeds its length
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WINDOW));
  // R2: once armed and left alone, the window only shrinks
  a_r2_window_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !set_i && !consume_i) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer import nvm_pkg::*; #(
  parameter int T_ATOMIC = 26368,
  parameter int T_SPLIT  = 13958
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  output logic       busy_o,
  output logic       done_o
);
  localparam int TMAX = (T_ATOMIC > T_SPLIT) ? T_ATOMIC : T_SPLIT;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)          cnt_d = (mode_i == OP_ATOMIC) ? TW'(T_ATOMIC) : TW'(T_SPLIT);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == TW'(1));

  // R4: the counter stays inside the longest duration
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(TMAX));
  // R4: no restart while an operation runs
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array import nvm_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_op,
  input  logic [7:0]        wr_data
);
  localparam int IW = $clog2(DEPTH);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_op)
        OP_ATOMIC:  cells[wr_addr[IW-1:0]] <= wr_data;
        OP_ERASE:   cells[wr_addr[IW-1:0]] <= 8'hFF;
        OP_PROGRAM: cells[wr_addr[IW-1:0]] <= cells[wr_addr[IW-1:0]] & wr_data;
        default:    ;
      endcase
    end
    if (rd_en) rd_data <= cells[rd_addr[IW-1:0]];
  end
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl import nvm_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int DEPTH      = 1024,
  parameter int T_ATOMIC   = 26368,
  parameter int T_SPLIT    = 13958,
  parameter int ARM_WINDOW = 4,
  parameter int RD_STALL   = 4,
  parameter int WR_STALL   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       flash_busy,
  output logic       cpu_stall,
  output logic       ready_irq
);
  localparam int HI_W      = ADDR_W - 8;
  localparam int PAD_W     = 8 - HI_W;
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW        = $clog2(STALL_MAX + 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [1:0]        mode_q, mode_d;
  logic              ien_q, ien_d;
  logic              rd_q, rd_d;
  logic [SW-1:0]     stall_q, stall_d;

  logic       armed, busy, commit;
  logic [7:0] mem_q;
  logic       ctrl_we, start, rd_go;
  logic [1:0] wr_mode;

  // decode of a control write
  assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);
  assign wr_mode = reg_wdata[CB_MODE+1:CB_MODE];
  assign start   = ctrl_we && reg_wdata[CB_WR] && armed && !busy && !flash_busy
                   && (wr_mode != OP_RSVD);
  assign rd_go   = ctrl_we && reg_wdata[CB_RD] && !busy && !start;

  nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
    .clk(clk), .rst_n(rst_n),
    .set_i(ctrl_we && reg_wdata[CB_ARM] && !busy),
    .consume_i(start),
    .armed_o(armed)
  );

  nvm_op_timer #(.T_ATOMIC(T_ATOMIC), .T_SPLIT(T_SPLIT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .mode_i(wr_mode),
    .busy_o(busy), .done_o(commit)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cells (
    .clk(clk),
    .rd_en(rd_go), .rd_addr(addr_q), .rd_data(mem_q),
    .wr_en(commit), .wr_addr(addr_q), .wr_op(mode_q), .wr_data(data_q)
  );

  always_comb begin
    addr_d  = addr_q;
    data_d  = data_q;
    mode_d  = mode_q;
    ien_d   = ien_q;
    rd_d    = rd_go;
    stall_d = stall_q;
    if (reg_we && !busy) begin
      if (reg_sel == SEL_ADDR_LO) addr_d[7:0]        = reg_wdata;
      if (reg_sel == SEL_ADDR_HI) addr_d[ADDR_W-1:8] = reg_wdata[HI_W-1:0];
    end
    if (rd_q)                                            data_d = mem_q;
    else if (reg_we && (reg_sel == SEL_DATA) && !busy)   data_d = reg_wdata;
    if (ctrl_we && !busy) mode_d = wr_mode;
    if (ctrl_we)          ien_d  = reg_wdata[CB_IEN];
    if (rd_go)                 stall_d = SW'(RD_STALL);
    else if (start)            stall_d = SW'(WR_STALL);
    else if (stall_q != '0)    stall_d = stall_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      ien_q   <= 1'b0;
      rd_q    <= 1'b0;
      stall_q <= '0;
    end else begin
      addr_q  <= addr_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
      ien_q   <= ien_d;
      rd_q    <= rd_d;
      stall_q <= stall_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_q[7:0];
      SEL_ADDR_HI: reg_rdata = {{PAD_W{1'b0}}, addr_q[ADDR_W-1:8]};
      SEL_DATA:    reg_rdata = data_q;
      default:     reg_rdata = {2'b00, mode_q, ien_q, armed, busy, 1'b0};
    endcase
  end

  assign cpu_stall = (stall_q != '0);
  assign ready_irq = ien_q && !busy;

  // R2: every operation was armed at the edge it started
  a_r2_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  // R5: never started while the external busy input was high
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(flash_busy));
  // R3: a running operation never carries the reserved code
  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode_q != OP_RSVD));
  // R8: the address is frozen during an operation
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  // R10: the request comes back when an enabled operation finishes
  a_r10_irq_return: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && ien_q) |-> ready_irq);
  // R9: stall never longer than the read hold
  a_r9_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= SW'(STALL_MAX));
endmodule

// File: tb/nvm_access_ctrl_test.sv
module nvm_access_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TA = 40;
  localparam int TS = 21;

  logic       clk, rst_n;
  logic [1:0] reg_sel;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       flash_busy, cpu_stall, ready_irq;

  int total = 0;
  int bad   = 0;
  logic       ien_b = 1'b1;
  logic [7:0] model [16];

  nvm_access_ctrl #(.T_ATOMIC(TA), .T_SPLIT(TS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_busy(flash_busy),
    .cpu_stall(cpu_stall), .ready_irq(ready_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(logic [1:0] m, logic ie, logic arm, logic wr, logic rd);
    return {2'b00, m, ie, arm, wr, rd};
  endfunction

  function automatic logic [7:0] cell_after(logic [1:0] m, logic [7:0] old, logic [7:0] d);
    case (m)
      2'b00:   return d;
      2'b01:   return 8'hFF;
      2'b10:   return old & d;
      default: return old;
    endcase
  endfunction

  function automatic int dur(logic [1:0] m);
    return (m == 2'b00) ? TA : TS;
  endfunction

  task automatic wr_reg(logic [1:0] s, logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [11:0] a, logic [7:0] d, logic [1:0] m, int gap);
    wr_reg(2'd0, a[7:0]);
    wr_reg(2'd1, {4'h0, a[11:8]});
    wr_reg(2'd2, d);
    wr_reg(2'd3, ctl(m, ien_b, 1'b1, 1'b0, 1'b0));
    idle(gap);
    wr_reg(2'd3, ctl(m, ien_b, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic wait_idle(output int busy_n, output int stall_n, output int irq_hits);
    logic [7:0] c;
    busy_n = 0; stall_n = 0; irq_hits = 0;
    for (int k = 0; k < 100000; k++) begin
      rd_reg(2'd3, c);
      if (cpu_stall) stall_n++;
      if (!c[1] && !cpu_stall) break;
      if (c[1]) busy_n++;
      if (c[1] && ready_irq) irq_hits++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(logic [11:0] a, output logic [7:0] v, output int stall_n);
    logic [7:0] c;
    wr_reg(2'd0, a[7:0]);
    wr_reg(2'd1, {4'h0, a[11:8]});
    wr_reg(2'd3, ctl(2'b00, ien_b, 1'b0, 1'b0, 1'b1));
    stall_n = 0;
    for (int k = 0; k < 100 && cpu_stall; k++) begin
      stall_n++;
      @(negedge clk);
    end
    rd_reg(2'd3, c);
    chk("R1 read strobe bit reads zero", c[0], 0);
    rd_reg(2'd2, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bn, sn, ih, seed_dummy;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00; flash_busy = 1'b0;
    seed_dummy = $urandom(32'h5EED);
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R11 reset state
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), v);
      chk($sformatf("R11 reg %0d after reset", s), v, 0);
    end
    chk("R11 stall after reset", cpu_stall, 0);
    chk("R11 irq after reset", ready_irq, 0);

    // R1 address and data readback
    wr_reg(2'd1, 8'hFF); rd_reg(2'd1, v); chk("R1 high address upper bits", v, 8'h0F);
    wr_reg(2'd0, 8'hA5); rd_reg(2'd0, v); chk("R1 low address", v, 8'hA5);
    wr_reg(2'd2, 8'h3C); rd_reg(2'd2, v); chk("R1 data register", v, 8'h3C);

    // R10 enable gating
    wr_reg(2'd3, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R10 irq with enable clear", ready_irq, 0);
    wr_reg(2'd3, ctl(2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R10 irq with enable set and idle", ready_irq, 1);

    // R2 arm bit self-clears
    wr_reg(2'd3, ctl(2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
    idle(3); rd_reg(2'd3, v); chk("R2 arm still set on last window cycle", v[2], 1);
    idle(1); rd_reg(2'd3, v); chk("R2 arm cleared after window", v[2], 0);

    // R2 strobe without arm
    wr_reg(2'd3, ctl(2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
    rd_reg(2'd3, v); chk("R2 unarmed strobe ignored", v[1], 0);

    // initialise cells 0..15 with atomic writes
    for (int i = 0; i < 16; i++) begin
      do_write(12'(i), 8'(8'hA0 + i), 2'b00, 0);
      wait_idle(bn, sn, ih);
      model[i] = 8'(8'hA0 + i);
    end

    // R4 R9 R10 R6 directed atomic write
    do_write(12'd3, 8'h5A, 2'b00, 1);
    wait_idle(bn, sn, ih);
    chk("R4 atomic busy length", bn, TA);
    chk("R9 write stall length", sn, 2);
    chk("R10 irq low while busy", ih, 0);
    chk("R10 irq after completion", ready_irq, 1);
    model[3] = 8'h5A;
    do_read(12'd3, v, sn);
    chk("R6 atomic stores data", v, 8'h5A);
    chk("R9 read stall length", sn, 4);

    // R6 erase only then program only
    do_write(12'd4, 8'h00, 2'b01, 2);
    wait_idle(bn, sn, ih);
    chk("R4 erase busy length", bn, TS);
    do_read(12'd4, v, sn); chk("R6 erase leaves FF", v, 8'hFF);
    do_write(12'd4, 8'h3C, 2'b10, 0);
    wait_idle(bn, sn, ih);
    chk("R4 program busy length", bn, TS);
    do_write(12'd4, 8'hF0, 2'b10, 0);
    wait_idle(bn, sn, ih);
    do_read(12'd4, v, sn); chk("R6 program ANDs bits", v, 8'h30);
    model[4] = 8'h30;

    // R2 late strobe refused, last-edge strobe accepted
    do_write(12'd2, 8'h00, 2'b00, 4);
    rd_reg(2'd3, v); chk("R2 late strobe refused", v[1], 0);
    wait_idle(bn, sn, ih);
    do_read(12'd2, v, sn); chk("R2 late strobe leaves cell", v, model[2]);
    do_write(12'd2, 8'h42, 2'b00, 3);
    wait_idle(bn, sn, ih);
    chk("R2 strobe on last window edge busy", bn, TA);
    do_read(12'd2, v, sn); chk("R2 strobe on last window edge stores", v, 8'h42);
    model[2] = 8'h42;

    // R3 reserved mode refused
    do_write(12'd6, 8'h00, 2'b11, 0);
    rd_reg(2'd3, v); chk("R3 reserved mode refused", v[1], 0);
    wait_idle(bn, sn, ih);
    do_read(12'd6, v, sn); chk("R3 reserved leaves cell", v, model[6]);

    // R5 external busy refuses
    flash_busy = 1'b1;
    do_write(12'd7, 8'h00, 2'b00, 0);
    rd_reg(2'd3, v); chk("R5 flash busy refuses", v[1], 0);
    flash_busy = 1'b0;
    wait_idle(bn, sn, ih);
    do_read(12'd7, v, sn); chk("R5 cell unchanged", v, model[7]);

    // R7 R8 changes during an operation
    do_write(12'd5, 8'h11, 2'b00, 0);
    idle(3);
    wr_reg(2'd3, ctl(2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
    rd_reg(2'd3, v); chk("R7 mode held while busy", v[5:4], 0);
    wr_reg(2'd0, 8'h77); rd_reg(2'd0, v); chk("R8 address held while busy", v, 8'h05);
    wr_reg(2'd2, 8'hEE); rd_reg(2'd2, v); chk("R8 data held while busy", v, 8'h11);
    wr_reg(2'd3, ctl(2'b00, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R8 read strobe while busy no stall", cpu_stall, 0);
    idle(2);
    rd_reg(2'd2, v); chk("R8 read strobe while busy keeps data", v, 8'h11);
    wait_idle(bn, sn, ih);
    model[5] = 8'h11;
    do_read(12'd5, v, sn); chk("R8 commit went to held address", v, 8'h11);

    // random sequences against the byte model
    for (int it = 0; it < 24; it++) begin
      logic [3:0] a;
      logic [1:0] m;
      logic [7:0] d;
      int g;
      a = 4'($urandom % 16);
      m = 2'($urandom % 3);
      d = 8'($urandom);
      g = int'($urandom % 4);
      do_write(12'(a), d, m, g);
      wait_idle(bn, sn, ih);
      chk($sformatf("R4 random busy length mode %0d", m), bn, dur(m));
      model[a] = cell_after(m, model[a], d);
      do_read(12'(a), v, sn);
      chk($sformatf("R6 random cell %0d mode %0d", a, m), v, model[a]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule